// File: doc/BRIEF.md
# Preemptive Prioritized Interrupt Controller

The controller gathers a wide set of hardware interrupt lines and a handful of software-raised request bits into one request line to a processor. Each source has a programmable 4-bit priority. The block registers the best pending source, meaning the one with the highest priority and, on a tie, the lowest index. It asserts the processor request whenever that priority is strictly above the current task priority. The vector of the winning source is its source index, and it appears both on an output port and in a readable register.

Acknowledging the request saves the current priority on an internal last-in-first-out stack and raises the current priority to that of the serviced source. Only a source of still higher priority can then preempt the handler. An end-of-service write restores the saved level. Software may also overwrite the current priority at any time, which lets a task lift itself to a ceiling level while it holds a shared resource.

All configuration goes through one flat register port. Each priority register sits at the address equal to its source index. The control registers sit at fixed addresses near the top of the space.

Top module: `prio_intc`

## Requirements
- R1: There are 199 sources. Indices 0 to 190 are the hw_req bits of the same number and indices 191 to 198 are bits 0 to 7 of the software request register. A source's vector is its index. vec_out shows the registered winner and reads 511 (9'h1FF) when no source with a nonzero priority is pending.
- R2: The priority of source i is held in the low 4 bits of register address i (0 to 198) and reads back there. It resets to 0. A source at priority 0 never causes a request, even while pending.
- R3: irq is high exactly when the registered winner's priority is strictly greater than the current priority.
- R4: When several pending sources share the highest priority, the lowest index wins.
- R5: Take a hw_req bit that goes high ahead of clock edge k while nothing else is eligible. irq and vec_out are still unchanged after edge k and show that source after edge k+1, which is within three cycles.
- R6: An acknowledge while irq is high pushes the current priority onto the stack and loads the winner's priority as the new current priority.
- R7: A write to address 0x1F3 (end of service) pops the top of the stack into the current priority.
- R8: A write to address 0x1F0 loads bits 3:0 into the current priority. A read there returns it. It resets to 0.
- R9: Bits 7:0 of address 0x1F1 hold the software requests and are written as a whole. A hardware source stays pending while its input is high.
- R10: Bit 0 of address 0x1F4 selects the acknowledge path. With 0, the irq_ack pin acknowledges. With 1, a read strobe (reg_re) at address 0x1F2 acknowledges and irq_ack is ignored. Address 0x1F2 returns the current vector in both modes, and in mode 0 reading it has no side effect.
- R11: The stack holds 15 entries. A push when full (the push is dropped, but the new priority is still loaded) or a pop when empty (the current priority is kept) sets bit 0 of address 0x1F5. That flag stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hw_req | input | 191 | Level-sensitive hardware requests |
| irq_ack | input | 1 | Acknowledge pin, used in mode 0 |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe (acknowledges at 0x1F2 in mode 1) |
| reg_addr | input | 9 | Register address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, combinational from reg_addr |
| irq | output | 1 | Request to the processor |
| vec_out | output | 9 | Vector of the current winner |

## Verification
Suppose the current priority or the stack holds a wrong value. The port shows it as soon as any source sits near the threshold: irq either fails to rise or rises in the cycle when it should be masked, and after a pop a restored level shows up at the next read of 0x1F0. A faulty winner register shows a wrong vec_out or a wrong tie-break one edge after the pending set changes. The bench model predicts irq and vec_out on every cycle, so such a fault surfaces within a cycle or two of the stimulus that exposes it.

// File: rtl/intc_pkg.sv
package intc_pkg;
  // register offsets above the per-source priority window
  localparam int ADDR_CUR  = 'h1F0;
  localparam int ADDR_SWR  = 'h1F1;
  localparam int ADDR_VEC  = 'h1F2;
  localparam int ADDR_EOS  = 'h1F3;
  localparam int ADDR_MODE = 'h1F4;
  localparam int ADDR_ERR  = 'h1F5;

  typedef enum logic {
    ACK_BY_PIN  = 1'b0,
    ACK_BY_READ = 1'b1
  } ack_mode_e;
endpackage

// File: rtl/intc_arbiter.sv
module intc_arbiter #(
  parameter int NSRC = 199,
  parameter int PW   = 4,
  parameter int VW   = 9
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NSRC-1:0]          pend,
  input  logic [NSRC-1:0][PW-1:0]  prio,
  output logic [VW-1:0]            win_vec,
  output logic [PW-1:0]            win_prio
);
  typedef struct packed {
    logic [VW-1:0] vec;
    logic [PW-1:0] lvl;
  } win_t;

  // ascending scan with strict compare: ties keep the lower index,
  // level 0 can never beat the initial value
  function automatic win_t pick(input logic [NSRC-1:0] p,
                                input logic [NSRC-1:0][PW-1:0] l);
    win_t w;
    w.vec = '1;
    w.lvl = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (p[i] && (l[i] > w.lvl)) begin
        w.vec = VW'(i);
        w.lvl = l[i];
      end
    end
    return w;
  endfunction

  win_t nxt;
  always_comb nxt = pick(pend, prio);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_vec  <= '1;
      win_prio <= '0;
    end else begin
      win_vec  <= nxt.vec;
      win_prio <= nxt.lvl;
    end
  end
endmodule

// File: rtl/intc_prio_stack.sv
module intc_prio_stack #(
  parameter int PW    = 4,
  parameter int DEPTH = 15,
  localparam int DW_  = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          pop,
  input  logic [PW-1:0] din,
  output logic [PW-1:0] top,
  output logic [DW_-1:0] depth,
  output logic          push_drop,
  output logic          pop_empty
);
  logic [PW-1:0] mem [DEPTH];
  logic full, empty;

  assign full      = (depth == DW_'(DEPTH));
  assign empty     = (depth == '0);
  assign push_drop = push && full;
  assign pop_empty = pop && empty;
  assign top       = empty ? '0 : mem[depth - 1'b1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      depth <= '0;
    end else if (push && !full) begin
      depth <= depth + 1'b1;
    end else if (pop && !empty) begin
      depth <= depth - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (push && !full) mem[depth] <= din;
  end
endmodule

// File: rtl/prio_intc.sv
module prio_intc
  import intc_pkg::*;
#(
  parameter int N_HW  = 191,
  parameter int N_SW  = 8,
  parameter int PW    = 4,
  parameter int VW    = 9,
  parameter int DEPTH = 15,
  parameter int AW    = 9,
  parameter int DW    = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N_HW-1:0] hw_req,
  input  logic            irq_ack,
  input  logic            reg_we,
  input  logic            reg_re,
  input  logic [AW-1:0]   reg_addr,
  input  logic [DW-1:0]   reg_wdata,
  output logic [DW-1:0]   reg_rdata,
  output logic            irq,
  output logic [VW-1:0]   vec_out
);
  localparam int NSRC = N_HW + N_SW;
  localparam int SDW  = $clog2(DEPTH + 1);

  logic [N_HW-1:0]           hw_q;
  logic [N_SW-1:0]           sw_q;
  logic [NSRC-1:0][PW-1:0]   prio_q;
  logic [PW-1:0]             cur_prio;
  logic [VW-1:0]             win_vec;
  logic [PW-1:0]             win_prio;
  ack_mode_e                 mode_q;
  logic                      err_q;

  // named events for the checker
  logic ack_fire, eos_fire, cur_wr;
  logic [PW-1:0]  stk_top;
  logic [SDW-1:0] stk_depth;
  logic push_drop, pop_empty;

  logic unused_wdata;
  assign unused_wdata = ^reg_wdata;

  assign irq     = (win_prio > cur_prio);
  assign vec_out = win_vec;

  assign ack_fire = irq && ((mode_q == ACK_BY_READ)
                            ? (reg_re && reg_addr == AW'(ADDR_VEC))
                            : irq_ack);
  assign eos_fire = reg_we && (reg_addr == AW'(ADDR_EOS));
  assign cur_wr   = reg_we && (reg_addr == AW'(ADDR_CUR));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hw_q   <= '0;
      sw_q   <= '0;
      mode_q <= ACK_BY_PIN;
    end else begin
      hw_q <= hw_req;
      if (reg_we && reg_addr == AW'(ADDR_SWR))  sw_q   <= reg_wdata[N_SW-1:0];
      if (reg_we && reg_addr == AW'(ADDR_MODE)) mode_q <= ack_mode_e'(reg_wdata[0]);
    end
  end

  generate
    for (genvar g = 0; g < NSRC; g++) begin : g_prio
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                             prio_q[g] <= '0;
        else if (reg_we && reg_addr == AW'(g))  prio_q[g] <= reg_wdata[PW-1:0];
      end
    end
  endgenerate

  // current priority: acknowledge first, then end of service, then direct write
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_prio <= '0;
      err_q    <= 1'b0;
    end else begin
      if (ack_fire)                    cur_prio <= win_prio;
      else if (eos_fire && !pop_empty) cur_prio <= stk_top;
      else if (cur_wr)                 cur_prio <= reg_wdata[PW-1:0];
      if (push_drop || pop_empty)      err_q    <= 1'b1;
    end
  end

  intc_arbiter #(.NSRC(NSRC), .PW(PW), .VW(VW)) u_arb (
    .clk      (clk),
    .rst_n    (rst_n),
    .pend     ({sw_q, hw_q}),
    .prio     (prio_q),
    .win_vec  (win_vec),
    .win_prio (win_prio)
  );

  intc_prio_stack #(.PW(PW), .DEPTH(DEPTH)) u_stk (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (ack_fire),
    .pop       (eos_fire && !ack_fire),
    .din       (cur_prio),
    .top       (stk_top),
    .depth     (stk_depth),
    .push_drop (push_drop),
    .pop_empty (pop_empty)
  );

  always_comb begin
    reg_rdata = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (reg_addr == AW'(i)) reg_rdata = DW'(prio_q[i]);
    end
    if (reg_addr == AW'(ADDR_CUR))  reg_rdata = DW'(cur_prio);
    if (reg_addr == AW'(ADDR_SWR))  reg_rdata = DW'(sw_q);
    if (reg_addr == AW'(ADDR_VEC))  reg_rdata = DW'(win_vec);
    if (reg_addr == AW'(ADDR_MODE)) reg_rdata = DW'(mode_q);
    if (reg_addr == AW'(ADDR_ERR))  reg_rdata = DW'(err_q);
  end
endmodule

// File: rtl/intc_chk.sv
module intc_chk #(
  parameter int NSRC  = 199,
  parameter int PW    = 4,
  parameter int VW    = 9,
  parameter int DEPTH = 15,
  localparam int SDW  = $clog2(DEPTH + 1)
) (
  input logic           clk,
  input logic           rst_n,
  input logic           irq,
  input logic [VW-1:0]  vec_out,
  input logic           ack_fire,
  input logic           eos_fire,
  input logic           cur_wr,
  input logic [PW-1:0]  wdata_lo,
  input logic [PW-1:0]  cur_prio,
  input logic [PW-1:0]  win_prio,
  input logic [SDW-1:0] stk_depth,
  input logic           err_q
);
  // R1
  vec_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (vec_out < VW'(NSRC)));
  // R6
  ack_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_fire |=> (cur_prio == $past(win_prio)));
  // R6
  ack_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_fire && stk_depth != SDW'(DEPTH)) |=> (stk_depth == $past(stk_depth) + 1'b1));
  // R7
  eos_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eos_fire && !ack_fire && stk_depth != '0) |=> (stk_depth == $past(stk_depth) - 1'b1));
  // R8
  cur_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_wr && !ack_fire) |=> (cur_prio == $past(wdata_lo)));
  // R11
  depth_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stk_depth <= SDW'(DEPTH));
  // R11
  overflow_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_fire && stk_depth == SDW'(DEPTH)) |=> err_q);
  // R11
  sticky_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> err_q);
endmodule

bind prio_intc intc_chk #(.NSRC(N_HW + N_SW), .PW(PW), .VW(VW), .DEPTH(DEPTH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .irq       (irq),
  .vec_out   (vec_out),
  .ack_fire  (ack_fire),
  .eos_fire  (eos_fire),
  .cur_wr    (cur_wr),
  .wdata_lo  (reg_wdata[PW-1:0]),
  .cur_prio  (cur_prio),
  .win_prio  (win_prio),
  .stk_depth (stk_depth),
  .err_q     (err_q)
);

// File: tb/test_prio_intc.sv
module test_prio_intc;
  localparam int CLK_PERIOD = 10;
  localparam int NH = 191;
  localparam int NS = 199;
  localparam int A_CUR = 'h1F0, A_SWR = 'h1F1, A_VEC = 'h1F2;
  localparam int A_EOS = 'h1F3, A_MODE = 'h1F4, A_ERR = 'h1F5;

  logic clk = 0, rst_n = 0;
  logic [NH-1:0] hw_req = '0;
  logic irq_ack = 0, reg_we = 0, reg_re = 0;
  logic [8:0] reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic irq;
  logic [8:0] vec_out;

  int n_vec = 0, n_bad = 0;
  bit running = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  prio_intc i_prio_intc (
    .clk(clk), .rst_n(rst_n), .hw_req(hw_req), .irq_ack(irq_ack),
    .reg_we(reg_we), .reg_re(reg_re), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq), .vec_out(vec_out)
  );

  // ---------------- behavioural reference ----------------
  int m_prio [NS];
  bit m_hw [NH];
  int m_sw, m_cur, m_wv, m_wp, m_mode;
  bit m_err;
  int m_stk [$];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      foreach (m_prio[i]) m_prio[i] = 0;
      foreach (m_hw[i]) m_hw[i] = 0;
      m_sw = 0; m_cur = 0; m_wv = 511; m_wp = 0; m_mode = 0; m_err = 0;
      m_stk.delete();
    end else begin
      bit ack, eos;
      int nv, np;
      ack = (m_wp > m_cur) &&
            ((m_mode == 1) ? (reg_re && reg_addr == A_VEC) : irq_ack);
      eos = !ack && reg_we && reg_addr == A_EOS;
      nv = 511; np = 0;
      for (int lvl = 15; lvl >= 1 && np == 0; lvl--) begin
        for (int s = 0; s < NS; s++) begin
          bit pend;
          pend = (s < NH) ? m_hw[s] : m_sw[s-NH];
          if (pend && m_prio[s] == lvl && np == 0) begin nv = s; np = lvl; end
        end
      end
      if (ack) begin
        if (m_stk.size() < 15) m_stk.push_back(m_cur); else m_err = 1;
        m_cur = m_wp;
      end else if (eos) begin
        if (m_stk.size() > 0) m_cur = m_stk.pop_back(); else m_err = 1;
      end else if (reg_we && reg_addr == A_CUR) m_cur = reg_wdata & 15;
      if (reg_we && reg_addr < NS) m_prio[reg_addr] = reg_wdata & 15;
      if (reg_we && reg_addr == A_SWR) m_sw = reg_wdata & 255;
      if (reg_we && reg_addr == A_MODE) m_mode = reg_wdata & 1;
      foreach (m_hw[i]) m_hw[i] = hw_req[i];
      m_wv = nv; m_wp = np;
    end
  end

  task automatic chk(string tag, int act, int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // every-cycle comparison of irq (R3) and vector (R1)
  always @(negedge clk) begin
    if (running && rst_n) begin
      chk("R3 irq", irq, (m_wp > m_cur) ? 1 : 0);
      chk("R1 vec_out", vec_out, m_wv);
    end
  end

  task automatic wr(int a, int d);
    @(negedge clk); reg_we = 1; reg_addr = 9'(a); reg_wdata = 16'(d);
    @(negedge clk); reg_we = 0;
  endtask

  task automatic rd(int a, bit strobe, output int d);
    @(negedge clk); reg_addr = 9'(a); reg_re = strobe;
    #1 d = reg_rdata;
    @(negedge clk); reg_re = 0;
  endtask

  task automatic ack_pin();
    @(negedge clk); irq_ack = 1;
    @(negedge clk); irq_ack = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0; hw_req = '0;
    idle(3);
    rst_n = 1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    int d;
    idle(4);
    rst_n = 1;
    running = 1;
    idle(1);
    // reset state
    chk("R3 reset irq", irq, 0);
    chk("R1 reset vec", vec_out, 511);
    rd(A_CUR, 0, d); chk("R8 reset cur", d, 0);
    rd(A_ERR, 0, d); chk("R11 reset err", d, 0);
    rd(5, 0, d); chk("R2 reset prio", d, 0);

    // priority register and level 0 masking
    wr(5, 3); rd(5, 0, d); chk("R2 prio readback", d, 3);
    @(negedge clk); hw_req[9] = 1;
    idle(4); chk("R2 level0 no irq", irq, 0);
    @(negedge clk); hw_req[9] = 0;
    idle(2);

    // latency
    @(negedge clk); hw_req[5] = 1;
    @(posedge clk); #1 chk("R5 after edge k", irq, 0);
    @(posedge clk); #1 chk("R5 after edge k+1", irq, 1);
    chk("R5 vector", vec_out, 5);

    // tie-break
    wr(3, 3);
    @(negedge clk); hw_req[3] = 1;
    idle(3); chk("R4 tie lowest", vec_out, 3);

    // nesting
    ack_pin(); rd(A_CUR, 0, d); chk("R6 cur after ack", d, 3);
    chk("R3 masked at equal", irq, 0);
    wr(40, 7);
    @(negedge clk); hw_req[40] = 1;
    idle(3); chk("R3 preempt irq", irq, 1); chk("R1 preempt vec", vec_out, 40);
    ack_pin(); rd(A_CUR, 0, d); chk("R6 nested cur", d, 7);
    @(negedge clk); hw_req[40] = 0;
    wr(A_EOS, 0); rd(A_CUR, 0, d); chk("R7 pop to 3", d, 3);
    wr(A_EOS, 0); rd(A_CUR, 0, d); chk("R7 pop to 0", d, 0);
    idle(2); chk("R7 irq back", irq, 1);

    // underflow
    wr(A_EOS, 0); rd(A_ERR, 0, d); chk("R11 underflow flag", d, 1);
    rd(A_CUR, 0, d); chk("R11 cur kept", d, 0);

    // software requests
    @(negedge clk); hw_req[3] = 0; hw_req[5] = 0;
    wr(191, 9); wr(198, 12); wr(A_SWR, 'h81);
    idle(3); chk("R9 sw high wins", vec_out, 198);
    rd(A_SWR, 0, d); chk("R9 sw readback", d, 'h81);
    wr(A_SWR, 'h01); idle(3); chk("R9 sw rewrite", vec_out, 191);
    wr(A_SWR, 0); idle(3);
    chk("R9 sw cleared", irq, 0); chk("R1 idle vector", vec_out, 511);

    // ceiling
    @(negedge clk); hw_req[40] = 1;
    wr(A_CUR, 8); idle(3); chk("R8 ceiling masks", irq, 0);
    wr(A_CUR, 6); idle(1); chk("R8 lowered ceiling", irq, 1);

    // read-acknowledge mode
    wr(A_MODE, 1);
    ack_pin(); rd(A_CUR, 0, d); chk("R10 pin ignored", d, 6);
    rd(A_VEC, 1, d); chk("R10 vector read", d, 40);
    rd(A_CUR, 0, d); chk("R6 read ack cur", d, 7);
    wr(A_EOS, 0); wr(A_MODE, 0);
    rd(A_VEC, 1, d); chk("R10 vec mode0", d, 40);
    rd(A_CUR, 0, d); chk("R10 mode0 read no ack", d, 6);
    rd(A_ERR, 0, d); chk("R11 sticky", d, 1);

    // overflow
    do_reset();
    idle(1);
    rd(A_ERR, 0, d); chk("R11 cleared by reset", d, 0);
    wr(0, 15);
    @(negedge clk); hw_req[0] = 1;
    idle(3);
    for (int j = 0; j < 16; j++) begin
      ack_pin();
      wr(A_CUR, 0);
      if (j == 14) begin rd(A_ERR, 0, d); chk("R11 full no error", d, 0); end
      if (j == 15) begin rd(A_ERR, 0, d); chk("R11 overflow flag", d, 1); end
    end
    @(negedge clk); hw_req[0] = 0;
    for (int j = 0; j < 15; j++) wr(A_EOS, 0);
    rd(A_CUR, 0, d); chk("R7 drained", d, 0);
    idle(3);

    running = 0;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule